// File: doc/BRIEF.md
# Serial Flash Command Front End with Deep Power-Down Filter

This block sits on the device side of a serial flash interface. It oversamples the serial clock, active-low chip select and serial data input with a system clock, assembles each frame, and passes the first byte of every well-formed frame to the rest of the device as a one-cycle command strobe with its opcode. Only frames whose length is a whole number of bytes count. A frame that stops in the middle of a byte is dropped.

The block also owns the deep power-down mode. A one-byte frame carrying the sleep opcode starts an entry timer, after which the device is asleep. While asleep it listens only for the wake opcode. Every other opcode, including the status read, is ignored. A wake frame starts a resume timer, and normal operation returns when it expires. The same wake opcode, when it is followed by at least three more bytes, also shifts the device identifier out on the serial data output. Both timers count system-clock cycles. A ready output is high only in normal operation.

Top module: `spi_pd_filter`

## Requirements
- R1: After reset the block is in normal operation: ready_o is 1, cmd_valid_o is 0 and miso_o is 0.
- R2: In normal operation, a frame is a byte-aligned frame when chip select (active low) rises after 8·k bits with k ≥ 1. Bits are taken MSB first on the rising edge of sclk_i. Each byte-aligned frame, other than a sleep-opcode frame, produces exactly one cmd_valid_o pulse of one cycle, and cmd_op_o equals the frame's first byte.
- R3: A frame that ends at a bit count that is not a multiple of 8 has no effect. It gives no strobe and no change of mode.
- R4: The sleep opcode 0xB9 acts only in a frame of exactly 8 bits. ready_o then falls within 8 cycles of chip select rising, no strobe is given, and the power-down mode is entered TDP_CYC cycles later. A longer 0xB9 frame is discarded.
- R5: Outside normal operation cmd_valid_o never pulses, whatever the opcode, including the status read 0x05.
- R6: In power-down, a byte-aligned frame whose first byte is the wake opcode 0xAB starts the resume timer. ready_o returns to 1 about TRES_CYC cycles after chip select rises, with no strobe, and commands are then accepted again.
- R7: Frames received while either timer is running are ignored. A wake frame during entry does not cancel the entry, and a sleep frame during resume does not cancel the resume.
- R8: In normal or power-down mode, in a 0xAB frame, from bit 24 onward miso_o carries DEV_ID MSB first, repeating every byte. Each bit is valid before the sclk_i rising edge that samples it. miso_o is 0 at every other time.
- R9: ready_o is 1 only in normal operation and is 0 during entry, power-down and resume.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the host |
| cs_ni | input | 1 | Chip select, active low |
| mosi_i | input | 1 | Serial data from the host |
| miso_o | output | 1 | Serial data to the host (identifier readout) |
| cmd_valid_o | output | 1 | One-cycle strobe for an accepted command |
| cmd_op_o | output | 8 | Opcode of the last accepted command |
| ready_o | output | 1 | High in normal operation only |

## Verification
The assertions assume that sclk_i, cs_ni and mosi_i change slowly compared with clk_i, so that every serial edge is seen by the synchronizers as a separate event, and that sclk_i rests low when chip select toggles. The bench holds each serial clock phase for five system cycles and leaves several cycles between chip select edges and the serial clock. It mixes random frames of random length and opcode with directed sequences that land frames inside the entry and resume windows.

// File: rtl/spd_pkg.sv
package spd_pkg;
  typedef enum logic [1:0] {
    ST_NORMAL = 2'd0,
    ST_ENTER  = 2'd1,
    ST_PDOWN  = 2'd2,
    ST_WAKE   = 2'd3
  } pwr_st_e;

  localparam logic [7:0] OP_SLEEP = 8'hB9;
  localparam logic [7:0] OP_WAKE  = 8'hAB;
  localparam int unsigned ID_BYTE = 3;
endpackage

// File: rtl/spd_sync.sv
module spd_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= RST_VAL;
      s2_q <= RST_VAL;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/spd_frame.sv
module spd_frame
  import spd_pkg::*;
#(
  parameter logic [7:0] DEV_ID = 8'h13
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sclk_s_i,
  input  logic       cs_n_s_i,
  input  logic       mosi_s_i,
  input  logic       id_en_i,
  output logic       frame_end_o,
  output logic [7:0] frame_op_o,
  output logic       frame_one_o,
  output logic       frame_aligned_o,
  output logic       miso_o
);
  localparam int unsigned BW = 3;
  localparam logic [BW-1:0] BYTE_SAT = '1;

  logic            sclk_q, cs_q;
  logic [2:0]      bit_idx_q;
  logic [BW-1:0]   byte_cnt_q;
  logic [7:0]      shreg_q, op_q;
  logic            miso_q;
  logic            sclk_rise;
  logic [7:0]      shreg_nx;

  assign sclk_rise = sclk_s_i & ~sclk_q;
  assign shreg_nx  = {shreg_q[6:0], mosi_s_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q     <= 1'b0;
      cs_q       <= 1'b1;
      bit_idx_q  <= '0;
      byte_cnt_q <= '0;
      shreg_q    <= '0;
      op_q       <= '0;
    end else begin
      sclk_q <= sclk_s_i;
      cs_q   <= cs_n_s_i;
      if (cs_n_s_i) begin
        bit_idx_q  <= '0;
        byte_cnt_q <= '0;
      end else if (sclk_rise) begin
        shreg_q   <= shreg_nx;
        bit_idx_q <= bit_idx_q + 3'd1;
        if (bit_idx_q == 3'd7) begin
          if (byte_cnt_q != BYTE_SAT) byte_cnt_q <= byte_cnt_q + 1'b1;
          if (byte_cnt_q == '0) op_q <= shreg_nx;
        end
      end
    end
  end

  // identifier shifts out once three bytes have passed in a wake frame
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) miso_q <= 1'b0;
    else if (!cs_n_s_i && id_en_i && byte_cnt_q >= BW'(ID_BYTE) && op_q == OP_WAKE)
      miso_q <= DEV_ID[~bit_idx_q];
    else
      miso_q <= 1'b0;
  end

  assign frame_end_o     = cs_n_s_i & ~cs_q;
  assign frame_op_o      = op_q;
  assign frame_one_o     = (byte_cnt_q == BW'(1));
  assign frame_aligned_o = (bit_idx_q == '0) && (byte_cnt_q != '0);
  assign miso_o          = miso_q;

  // R3
  frame_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_s_i |=> (bit_idx_q == '0 && byte_cnt_q == '0));
  // R8
  miso_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_s_i |=> !miso_o);
  // R8
  miso_early_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_cnt_q < BW'(ID_BYTE) && $stable(byte_cnt_q)) |=> !miso_o || $past(byte_cnt_q >= BW'(ID_BYTE)));
endmodule

// File: rtl/spd_pwr_fsm.sv
module spd_pwr_fsm
  import spd_pkg::*;
#(
  parameter int unsigned TDP_CYC  = 200,
  parameter int unsigned TRES_CYC = 300
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       frame_end_i,
  input  logic [7:0] frame_op_i,
  input  logic       frame_one_i,
  input  logic       frame_aligned_i,
  output logic       cmd_valid_o,
  output logic [7:0] cmd_op_o,
  output logic       ready_o,
  output logic       id_en_o
);
  localparam int unsigned TMAX = (TDP_CYC > TRES_CYC) ? TDP_CYC : TRES_CYC;
  localparam int unsigned TW   = $clog2(TMAX + 1);

  pwr_st_e       st_q;
  logic [TW-1:0] tmr_q;
  logic          cmd_valid_q;
  logic [7:0]    cmd_op_q;
  logic          good_frame;

  assign good_frame = frame_end_i & frame_aligned_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_NORMAL;
      tmr_q       <= '0;
      cmd_valid_q <= 1'b0;
      cmd_op_q    <= '0;
    end else begin
      cmd_valid_q <= 1'b0;
      unique case (st_q)
        ST_NORMAL: if (good_frame) begin
          if (frame_op_i == OP_SLEEP) begin
            if (frame_one_i) begin
              st_q  <= ST_ENTER;
              tmr_q <= TW'(TDP_CYC - 1);
            end
          end else begin
            cmd_valid_q <= 1'b1;
            cmd_op_q    <= frame_op_i;
          end
        end
        ST_ENTER: begin
          if (tmr_q == '0) st_q <= ST_PDOWN;
          else             tmr_q <= tmr_q - 1'b1;
        end
        ST_PDOWN: if (good_frame && frame_op_i == OP_WAKE) begin
          st_q  <= ST_WAKE;
          tmr_q <= TW'(TRES_CYC - 1);
        end
        ST_WAKE: begin
          if (tmr_q == '0) st_q <= ST_NORMAL;
          else             tmr_q <= tmr_q - 1'b1;
        end
        default: st_q <= ST_NORMAL;
      endcase
    end
  end

  assign cmd_valid_o = cmd_valid_q;
  assign cmd_op_o    = cmd_op_q;
  assign ready_o     = (st_q == ST_NORMAL);
  assign id_en_o     = (st_q == ST_NORMAL) || (st_q == ST_PDOWN);

  // R5
  strobe_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_o |-> st_q == ST_NORMAL);
  // R4
  enter_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_ENTER && tmr_q != '0) |=> st_q == ST_ENTER);
  // R6
  wake_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAKE && tmr_q != '0) |=> st_q == ST_WAKE);
  // R7
  pdown_exit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_PDOWN && !good_frame) |=> st_q == ST_PDOWN);
  // R3
  normal_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_NORMAL && !good_frame) |=> (st_q == ST_NORMAL && !cmd_valid_o));
endmodule

// File: rtl/spi_pd_filter.sv
module spi_pd_filter
  import spd_pkg::*;
#(
  parameter int unsigned TDP_CYC  = 200,
  parameter int unsigned TRES_CYC = 300,
  parameter logic [7:0]  DEV_ID   = 8'h13
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sclk_i,
  input  logic       cs_ni,
  input  logic       mosi_i,
  output logic       miso_o,
  output logic       cmd_valid_o,
  output logic [7:0] cmd_op_o,
  output logic       ready_o
);
  logic [2:0] pins_s;
  logic       frame_end, frame_one, frame_aligned, id_en;
  logic [7:0] frame_op;

  spd_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sclk_i, cs_ni, mosi_i}),
    .q_o   (pins_s)
  );

  spd_frame #(.DEV_ID(DEV_ID)) u_frame (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .sclk_s_i       (pins_s[2]),
    .cs_n_s_i       (pins_s[1]),
    .mosi_s_i       (pins_s[0]),
    .id_en_i        (id_en),
    .frame_end_o    (frame_end),
    .frame_op_o     (frame_op),
    .frame_one_o    (frame_one),
    .frame_aligned_o(frame_aligned),
    .miso_o         (miso_o)
  );

  spd_pwr_fsm #(.TDP_CYC(TDP_CYC), .TRES_CYC(TRES_CYC)) u_fsm (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .frame_end_i    (frame_end),
    .frame_op_i     (frame_op),
    .frame_one_i    (frame_one),
    .frame_aligned_i(frame_aligned),
    .cmd_valid_o    (cmd_valid_o),
    .cmd_op_o       (cmd_op_o),
    .ready_o        (ready_o),
    .id_en_o        (id_en)
  );
endmodule

// File: tb/spi_pd_filter_tb_top.sv
module spi_pd_filter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 5;
  localparam int TDP        = 200;
  localparam int TRES       = 300;
  localparam logic [7:0] ID = 8'h13;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic miso, cmd_valid, ready;
  logic [7:0] cmd_op;

  int total = 0, bad = 0;
  int strobe_cnt = 0;
  logic [7:0] strobe_op = '0;
  int miso_err;
  logic [7:0] id_rx;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_pd_filter #(.TDP_CYC(TDP), .TRES_CYC(TRES), .DEV_ID(ID)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_ni(cs_n), .mosi_i(mosi),
    .miso_o(miso), .cmd_valid_o(cmd_valid), .cmd_op_o(cmd_op), .ready_o(ready)
  );

  always @(posedge clk) if (cmd_valid) begin
    strobe_cnt++;
    strobe_op = cmd_op;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  function automatic logic exp_miso(input logic [7:0] op, input int i, input bit id_ok);
    if (id_ok && op == 8'hAB && i >= 24) return ID[7 - ((i - 24) % 8)];
    return 1'b0;
  endfunction

  task automatic send_frame(input logic [7:0] op, input int nbits, input bit id_ok);
    miso_err = 0;
    id_rx = '0;
    @(negedge clk);
    cs_n = 1'b0;
    wait_clk(HALF);
    for (int i = 0; i < nbits; i++) begin
      mosi = (i < 8) ? op[7-i] : 1'($urandom);
      wait_clk(HALF);
      if (miso !== exp_miso(op, i, id_ok)) miso_err++;
      if (i >= 24 && i < 32) id_rx[31-i] = miso;
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
    end
    wait_clk(HALF);
    cs_n = 1'b1;
  endtask

  task automatic count_strobes(input int n, output int cnt);
    int s0;
    s0 = strobe_cnt;
    wait_clk(n);
    cnt = strobe_cnt - s0;
  endtask

  task automatic wake_latency(output int n);
    n = 0;
    while (!ready && n < 2000) begin
      @(negedge clk);
      n++;
    end
  endtask

  bit done = 0;
  initial begin
    for (int c = 0; c < 200000; c++) @(negedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int sc, lat;
    bit pd;
    logic [7:0] op;
    int nb, sel;
    void'($urandom(32'h5EED1234));

    wait_clk(4);
    // R1 reset state
    chk(ready === 1'b1, "R1", "ready in reset", ready, 1);
    rst_n = 1'b1;
    wait_clk(4);
    chk(ready === 1'b1 && cmd_valid === 1'b0 && miso === 1'b0, "R1", "idle outputs",
        {ready, cmd_valid, miso}, 3'b100);

    // R2 single byte and multi byte commands
    send_frame(8'h05, 8, 1); count_strobes(12, sc);
    chk(sc == 1 && strobe_op == 8'h05, "R2", "status strobe", sc, 1);
    send_frame(8'h03, 32, 1); count_strobes(12, sc);
    chk(sc == 1 && strobe_op == 8'h03, "R2", "read strobe", strobe_op, 8'h03);

    // R3 misaligned frames
    send_frame(8'h06, 12, 1); count_strobes(12, sc);
    chk(sc == 0, "R3", "12-bit frame", sc, 0);
    send_frame(8'h05, 5, 1); count_strobes(12, sc);
    chk(sc == 0 && ready, "R3", "5-bit frame", sc, 0);

    // R8 identifier readout in normal mode
    send_frame(8'hAB, 40, 1); count_strobes(12, sc);
    chk(id_rx == ID, "R8", "id normal", id_rx, ID);
    chk(miso_err == 0, "R8", "miso bits", miso_err, 0);
    chk(sc == 1 && strobe_op == 8'hAB, "R2", "id strobe", strobe_op, 8'hAB);

    // R4 long sleep frame discarded
    send_frame(8'hB9, 16, 1); count_strobes(12, sc);
    chk(sc == 0 && ready, "R4", "long sleep", {sc[3:0], ready}, 1);

    // R4 valid sleep
    send_frame(8'hB9, 8, 1); count_strobes(8, sc);
    chk(!ready && sc == 0, "R4", "sleep ready low", ready, 0);
    // R7 wake during entry ignored
    send_frame(8'hAB, 8, 0); count_strobes(12, sc);
    wait_clk(TDP + TRES + 50);
    chk(!ready, "R7", "wake during entry", ready, 0);
    // R5 status read ignored while asleep
    send_frame(8'h05, 8, 1); count_strobes(12, sc);
    chk(sc == 0, "R5", "status in pd", sc, 0);
    // R9 ready low in power-down
    chk(!ready, "R9", "ready in pd", ready, 0);
    // R8 identifier in pd, R6 wake latency
    send_frame(8'hAB, 32, 1);
    wake_latency(lat);
    chk(id_rx == ID && miso_err == 0, "R8", "id pd", id_rx, ID);
    chk(lat >= TRES && lat <= TRES + 6, "R6", "wake latency", lat, TRES + 3);
    count_strobes(12, sc);
    chk(sc == 0, "R6", "no strobe on wake", sc, 0);

    // R3/R6 misaligned wake in pd ignored
    send_frame(8'hB9, 8, 1); wait_clk(TDP + 20);
    send_frame(8'hAB, 12, 1); wait_clk(TRES + 50);
    chk(!ready, "R3", "misaligned wake", ready, 0);
    send_frame(8'hAB, 8, 1);
    // R7 frames during resume ignored
    send_frame(8'hB9, 8, 0);
    send_frame(8'h05, 8, 0);
    count_strobes(4, sc);
    chk(sc == 0 && !ready, "R7", "frames during resume", sc, 0);
    wait_clk(TRES);
    chk(ready, "R7", "resume not cancelled", ready, 1);
    send_frame(8'h05, 8, 1); count_strobes(12, sc);
    chk(sc == 1 && strobe_op == 8'h05, "R6", "accept after wake", sc, 1);

    // random frames against a bench model
    pd = 0;
    for (int n = 0; n < 80; n++) begin
      bit al, exp_pd, id_ok;
      int exp_sc;
      sel = $urandom % 6;
      op = (sel == 0) ? 8'hB9 : (sel == 1) ? 8'hAB : (sel == 2) ? 8'h05 :
           (sel == 3) ? 8'h03 : 8'($urandom);
      sel = $urandom % 6;
      nb = (sel == 0 || sel == 1) ? 8 : (sel == 2) ? 16 : (sel == 3) ? 32 :
           (sel == 4) ? 40 : 8 * ($urandom % 4) + 1 + ($urandom % 7);
      al = (nb % 8) == 0;
      exp_sc = 0; exp_pd = pd;
      if (!pd) begin
        if (al && op == 8'hB9 && nb == 8) exp_pd = 1;
        else if (al && op != 8'hB9) exp_sc = 1;
      end else if (al && op == 8'hAB) exp_pd = 0;
      id_ok = 1;
      send_frame(op, nb, id_ok);
      count_strobes(12, sc);
      chk(sc == exp_sc && (exp_sc == 0 || strobe_op == op), "R2", "random strobe", sc, exp_sc);
      chk(miso_err == 0, "R8", "random miso", miso_err, 0);
      wait_clk(TDP + TRES + 20);
      chk(ready == !exp_pd, "R9", "random ready", ready, !exp_pd);
      pd = exp_pd;
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule